// File: doc/BRIEF.md
# Multichannel TDM Channel Packer

The block takes one sample from each of `NUM_CH` channels, all presented at once on a wide parallel input, and spreads them over a time-division frame of `PERIOD` clock cycles. A one-cycle load strobe copies the whole input vector into a holding register and starts a frame. The frame then goes out on the smallest set of data wires that can carry every channel within one period. A single valid bit and a single 8-bit slot count describe all the wires together.

The channels are shared out as evenly as possible. The first `NUM_CH mod wires` wires take one channel more than the others. On each wire, consecutive channel numbers occupy consecutive slots from the start of the frame. The slot count is 0 in the first cycle of every frame and rises by one in each valid cycle. It tells the receiver where it is in the frame, and the receiver recovers the channel on each wire from that count and the fixed layout. A load strobe that arrives while a frame is still in progress is dropped and latches a sticky overrun flag. A strobe in the final cycle of a frame is accepted, so frames can follow each other with no gap.

Top module: `tdm_channel_packer`

## Requirements
- R1: The data output has `ceil(NUM_CH / PERIOD)` wires of `SAMPLE_W` bits each. Wire w occupies bits `[w*SAMPLE_W +: SAMPLE_W]`.
- R2: With W wires, wire w carries `floor(NUM_CH/W)` channels, plus one more when `w < NUM_CH mod W`. Wire 0 starts at channel 0, and each later wire starts right after the last channel of the wire before it.
- R3: In slot s of a frame, wire w carries the sample of channel `first(w)+s` when s is less than the channel count of that wire.
- R4: `out_valid` is 1 in slots 0 through L-1 of a frame, where L is the largest per-wire channel count. It is 0 in the remaining slots of the frame and whenever no frame is running.
- R5: `out_chan` equals the slot index while `out_valid` is 1, and is 0 whenever `out_valid` is 0.
- R6: When `PERIOD` is 1, `out_chan` is 0 in every cycle and all channels appear in parallel in a single valid cycle.
- R7: A wire with no channel in the current slot drives zero, even when `out_valid` is 1.
- R8: Slot 0 of a frame appears in the cycle right after the rising edge that samples an accepted strobe. A frame lasts `PERIOD` cycles. A strobe seen in the last slot starts the next frame with no idle cycle.
- R9: A strobe seen during any slot other than the last one of a running frame is ignored and does not change the frame in progress. It sets `overrun`, which then stays at 1 until reset.
- R10: Samples are taken only on an accepted strobe. Changes on `in_samples` at any other time have no effect on the outputs.
- R11: While `rst_n` is low, all outputs are zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_load | input | 1 | Frame-start strobe, one cycle |
| in_samples | input | NUM_CH*SAMPLE_W | One sample per channel; channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| out_valid | output | 1 | Shared valid for all data wires |
| out_chan | output | 8 | Slot count within the frame |
| out_data | output | NUM_WIRES*SAMPLE_W | Data wires; wire w at bits [w*SAMPLE_W +: SAMPLE_W] |
| overrun | output | 1 | Sticky flag for an ignored strobe |

## Verification
Every output comes from a register. Slot 0 of a frame is therefore visible one cycle after the rising edge that samples an accepted strobe, and slot s is visible s cycles after that. The overrun flag rises at the same edge that samples the rejected strobe. The bench updates its behavioural model at each rising edge from the inputs it drove before that edge. At the following falling edge it compares every output against the model, so each result is checked in the exact cycle it is due. Four parameter sets cover uneven and even splits, a tail of unused slots and the single-cycle period. The load strobe is driven both in a regular back-to-back pattern and in a random one, and the samples change every cycle.

// File: rtl/tdm_pack_pkg.sv
// Package: layout arithmetic shared by the channel packer and its checker.
// Assumes the channel count and period are positive; callers guard zero.
package tdm_pack_pkg;

    localparam int CHAN_W = 8;

    // Number of wires needed to fit all channels in one period.
    function automatic int wire_count(input int nch, input int per);
        if (per < 1) return 1;
        return (nch + per - 1) / per;
    endfunction

    // Channels carried by wire w when nch are spread over nw wires.
    function automatic int lane_len(input int nch, input int nw, input int w);
        return (nch / nw) + ((w < (nch % nw)) ? 1 : 0);
    endfunction

    // Index of the first channel carried by wire w.
    function automatic int lane_first(input int nch, input int nw, input int w);
        int ext;
        ext = nch % nw;
        return w * (nch / nw) + ((w < ext) ? w : ext);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame timer: tracks the slot position inside a running frame, decides
// whether a load strobe is accepted and latches the overrun flag.
// Assumes PERIOD >= 1. A strobe in the last slot starts a new frame.
module tdm_frame_timer #(
    parameter int PERIOD = 3,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    output logic              load_ok,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic              overrun
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PERIOD - 1);

    logic at_last;

    // Purpose: flag the last slot and decide acceptance of the strobe.
    always_comb begin
        at_last = active && (slot == LAST_SLOT);
        load_ok = load_req && (!active || at_last);
    end

    // Purpose: advance the slot counter and the frame-running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= '0;
        end else if (load_ok) begin
            active <= 1'b1;
            slot   <= '0;
        end else if (at_last) begin
            active <= 1'b0;
            slot   <= '0;
        end else if (active) begin
            slot <= slot + 1'b1;
        end
    end

    // Purpose: sticky record of a strobe that was dropped mid-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (load_req && !load_ok) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/tdm_lane_mux.sv
// Lane multiplexer: picks the sample for one data wire from the slice of
// held channels that this wire carries, by slot index. Drives zero when
// no frame runs or the slot is past the wire's channel count.
// Assumes LEN >= 1 and LEN <= 2**SLOT_W.
module tdm_lane_mux #(
    parameter int SAMPLE_W = 12,
    parameter int LEN      = 3,
    parameter int SLOT_W   = 2
) (
    input  logic                    active,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [LEN*SAMPLE_W-1:0] lane_samples,
    output logic [SAMPLE_W-1:0]     lane_data
);
    // Purpose: select this wire's channel for the current slot, else zero.
    always_comb begin
        lane_data = '0;
        if (active) begin
            for (int i = 0; i < LEN; i++) begin
                if (slot == SLOT_W'(i)) begin
                    lane_data = lane_samples[i*SAMPLE_W +: SAMPLE_W];
                end
            end
        end
    end

endmodule

// File: rtl/tdm_channel_packer.sv
// Multichannel TDM channel packer (top). Captures NUM_CH samples on an
// accepted load strobe and emits them over PERIOD cycles on the minimum
// number of wires. The channels are spread evenly, each wire fills its
// time slots first, and one valid and one 8-bit slot count cover all
// wires. Assumes PERIOD >= 1, NUM_CH >= 1 and at most 256 valid slots.
module tdm_channel_packer #(
    parameter int  NUM_CH    = 5,
    parameter int  PERIOD    = 3,
    parameter int  SAMPLE_W  = 12,
    localparam int NUM_WIRES = tdm_pack_pkg::wire_count(NUM_CH, PERIOD)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_load,
    input  logic [NUM_CH*SAMPLE_W-1:0]    in_samples,
    output logic                          out_valid,
    output logic [tdm_pack_pkg::CHAN_W-1:0] out_chan,
    output logic [NUM_WIRES*SAMPLE_W-1:0] out_data,
    output logic                          overrun
);
    localparam int CW      = tdm_pack_pkg::CHAN_W;
    localparam int SLOT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int MAX_LEN = tdm_pack_pkg::lane_len(NUM_CH, NUM_WIRES, 0);
    localparam logic [SLOT_W:0] MAX_LEN_V = (SLOT_W + 1)'(MAX_LEN);

    // Purpose: reject parameter sets the layout cannot represent.
    if (PERIOD < 1 || NUM_CH < 1 || NUM_CH > 256 * NUM_WIRES) begin : g_bad_cfg
        $fatal(1, "tdm_channel_packer: unsupported NUM_CH/PERIOD");
    end

    logic                       load_ok;
    logic                       active;
    logic [SLOT_W-1:0]          slot;
    logic [NUM_CH*SAMPLE_W-1:0] held;
    logic [CW-1:0]              slot_ext;

    tdm_frame_timer #(
        .PERIOD (PERIOD),
        .SLOT_W (SLOT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (in_load),
        .load_ok  (load_ok),
        .active   (active),
        .slot     (slot),
        .overrun  (overrun)
    );

    // Purpose: hold the input vector for the duration of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load_ok) begin
            held <= in_samples;
        end
    end

    // Purpose: one multiplexer per wire, each over its own channel slice.
    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_lane
        localparam int LEN   = tdm_pack_pkg::lane_len(NUM_CH, NUM_WIRES, w);
        localparam int FIRST = tdm_pack_pkg::lane_first(NUM_CH, NUM_WIRES, w);
        tdm_lane_mux #(
            .SAMPLE_W (SAMPLE_W),
            .LEN      (LEN),
            .SLOT_W   (SLOT_W)
        ) u_lane (
            .active       (active),
            .slot         (slot),
            .lane_samples (held[FIRST*SAMPLE_W +: LEN*SAMPLE_W]),
            .lane_data    (out_data[w*SAMPLE_W +: SAMPLE_W])
        );
    end

    // Purpose: fit the slot index to the 8-bit count width.
    if (SLOT_W >= CW) begin : g_chan_trunc
        assign slot_ext = slot[CW-1:0];
    end else begin : g_chan_pad
        assign slot_ext = {{(CW - SLOT_W){1'b0}}, slot};
    end

    // Purpose: shared valid and slot count for all wires.
    always_comb begin
        out_valid = active && ({1'b0, slot} < MAX_LEN_V);
        out_chan  = out_valid ? slot_ext : '0;
    end

endmodule

// File: rtl/tdm_packer_checks.sv
// Checker: temporal properties of the channel packer, bound to every
// instance of the top module. Reads ports plus the timer's accept signal.
module tdm_packer_checks #(
    parameter int DW      = 24,
    parameter int MAX_LEN = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_load,
    input logic          load_ok,
    input logic          out_valid,
    input logic [7:0]    out_chan,
    input logic [DW-1:0] out_data,
    input logic          overrun
);
    // R5: count is zero outside valid cycles
    a_r5_chan_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_chan == 8'd0);

    // R5: count steps by one between consecutive valid cycles of a frame
    a_r5_chan_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && out_chan != 8'd0)
            |-> out_chan == $past(out_chan) + 8'd1);

    // R7: data wires are zero when nothing is valid
    a_r7_data_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);

    // R8: an accepted strobe puts slot 0 out in the next cycle
    a_r8_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (out_valid && out_chan == 8'd0));

    // R4: after the last valid slot the frame restarts or goes quiet
    a_r4_valid_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chan == 8'(MAX_LEN - 1))
            |=> (!out_valid || out_chan == 8'd0));

    // R9: overrun never clears and only rises after a strobe
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(in_load));

endmodule

bind tdm_channel_packer tdm_packer_checks #(
    .DW      (NUM_WIRES * SAMPLE_W),
    .MAX_LEN (MAX_LEN)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_load   (in_load),
    .load_ok   (load_ok),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data),
    .overrun   (overrun)
);

// File: tb/tdm_channel_packer_test.sv
// Harness: one packer configuration with a behavioural frame model that
// is compared against the outputs at every falling clock edge.
module tdm_packer_harness #(
    parameter int N  = 5,
    parameter int P  = 3,
    parameter int SW = 12
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_checks,
    output int   n_errors,
    output logic done
);
    localparam int NW = (N + P - 1) / P;

    logic              in_load;
    logic [N*SW-1:0]   in_samples;
    logic              out_valid;
    logic [7:0]        out_chan;
    logic [NW*SW-1:0]  out_data;
    logic              overrun;

    tdm_channel_packer #(.NUM_CH(N), .PERIOD(P), .SAMPLE_W(SW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_load    (in_load),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_data   (out_data),
        .overrun    (overrun)
    );

    // Reference layout and state
    int          cnt [NW];
    int          first [NW];
    int          maxlen;
    logic [SW-1:0] model_held [N];
    int          pos = -1;
    bit          model_ov = 0;
    bit          cmp_en = 0;

    initial begin
        int nxt;
        nxt = 0;
        maxlen = 0;
        for (int w = 0; w < NW; w++) begin
            cnt[w] = N / NW;
            if (w < N % NW) cnt[w]++;
            first[w] = nxt;
            nxt += cnt[w];
            if (cnt[w] > maxlen) maxlen = cnt[w];
        end
        for (int c = 0; c < N; c++) model_held[c] = '0;
        n_checks = 0;
        n_errors = 0;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s N=%0d P=%0d t=%0t actual %0d expected %0d",
                     tag, N, P, $time, act, exp);
        end
    endtask

    // Model: advance the frame at each rising edge
    always @(posedge clk) begin
        bit acc;
        cmp_en = 1;
        if (!rst_n) begin
            pos = -1;
            model_ov = 0;
            for (int c = 0; c < N; c++) model_held[c] = '0;
        end else begin
            acc = in_load && (pos < 0 || pos == P - 1);
            if (in_load && !acc) model_ov = 1;
            if (acc) begin
                for (int c = 0; c < N; c++) model_held[c] = in_samples[c*SW +: SW];
                pos = 0;
            end else if (pos >= 0) begin
                pos = (pos == P - 1) ? -1 : pos + 1;
            end
        end
    end

    // Compare all outputs halfway through each cycle
    always @(negedge clk) begin
        if (cmp_en) begin
            bit  ev;
            int  ech;
            string vt;
            ev  = (pos >= 0) && (pos < maxlen);
            ech = ev ? pos : 0;
            vt  = !rst_n ? "R11 valid" : (pos == 0 ? "R8 valid" : "R4 valid");
            chk(vt, out_valid, ev);
            chk(!rst_n ? "R11 chan" : (P == 1 ? "R6 chan" : "R5 chan"), out_chan, ech);
            for (int w = 0; w < NW; w++) begin
                longint ed;
                bit used;
                used = ev && (pos < cnt[w]);
                ed = used ? longint'(model_held[first[w] + pos]) : 0;
                chk(!rst_n ? "R11 data" : (used ? "R2 R3 R10 data" : "R7 data"),
                    out_data[w*SW +: SW], ed);
            end
            chk(!rst_n ? "R11 overrun" : "R9 overrun", overrun, model_ov);
        end
    end

    task automatic drive(input bit ld);
        in_load = ld;
        for (int c = 0; c < N; c++) begin
            logic [31:0] r;
            r = $urandom;
            in_samples[c*SW +: SW] = r[SW-1:0];
        end
    endtask

    // Stimulus: regular back-to-back frames, idle gap, then random strobes
    initial begin
        done = 0;
        in_load = 0;
        in_samples = '0;
        @(posedge rst_n);
        @(negedge clk);
        chk("R1 width", $bits(out_data), NW * SW);
        for (int i = 0; i < 4 * P; i++) begin
            drive(i % P == 0);
            @(negedge clk);
        end
        for (int i = 0; i < 2 * P + 2; i++) begin
            drive(0);
            @(negedge clk);
        end
        for (int i = 0; i < 300; i++) begin
            drive(($urandom % 3) == 0);
            @(negedge clk);
        end
        drive(0);
        repeat (P + 2) @(negedge clk);
        done = 1;
    end
endmodule

// Bench top: clock, reset, four packer configurations, watchdog, summary.
module tdm_channel_packer_test;
    logic clk = 0;
    logic rst_n = 0;
    int   c0, c1, c2, c3, e0, e1, e2, e3;
    logic d0, d1, d2, d3;
    int   checks, errors;

    always #4 clk = ~clk;

    // Uneven split 3+2 (default layout)
    tdm_packer_harness #(.N(5),  .P(3), .SW(12)) h_uneven (.clk, .rst_n, .n_checks(c0), .n_errors(e0), .done(d0));
    // Even split 2+2 with an unused slot
    tdm_packer_harness #(.N(4),  .P(3), .SW(9))  h_even   (.clk, .rst_n, .n_checks(c1), .n_errors(e1), .done(d1));
    // Three wires 5+4+4 in a six-cycle frame
    tdm_packer_harness #(.N(13), .P(6), .SW(8))  h_wide   (.clk, .rst_n, .n_checks(c2), .n_errors(e2), .done(d2));
    // Single-cycle period, all channels parallel
    tdm_packer_harness #(.N(3),  .P(1), .SW(10)) uut      (.clk, .rst_n, .n_checks(c3), .n_errors(e3), .done(d3));

    initial begin
        int cyc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        cyc = 0;
        while (!(d0 && d1 && d2 && d3) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        checks = c0 + c1 + c2 + c3;
        errors = e0 + e1 + e2 + e3;
        if (!(d0 && d1 && d2 && d3)) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule